// File: doc/BRIEF.md
# Two-Wire Bus Line Front End

This block sits between the raw clock and data pins of a two-wire serial bus and the protocol engine of a slave. It runs entirely on the system clock. Each line passes through a synchronizer and then a counter filter, so a pulse shorter than a set number of clock cycles never reaches the engine. From the filtered levels the block produces one-cycle event strobes: bus start, bus stop, clock rise and clock fall. It also keeps a busy flag that is set by a start and cleared by a stop.

On the output side the engine asks for the data line to be pulled low or released. The block holds back any change of that request until the filtered clock is low and a set number of cycles have passed since the clock fell. This way the slave's own data changes cannot land in the falling-edge region of the clock and be seen as a start or a stop. Both the filter length and the hold time are given in system-clock cycles, so they can be set for the clock in use. For example, 10 cycles at 200 MHz gives 50 ns, and 60 cycles gives 300 ns.

Top module: `twowire_line_frontend`

## Requirements
- R1: After reset both filtered levels read 1, all four event strobes are 0, `bus_busy` is 0 and `dat_oe` is 0 (data line released).
- R2: A pin level held for fewer than `FILT_CYCLES` clock edges is rejected: the filtered level does not change and no event is raised. A level held for exactly `FILT_CYCLES` edges is accepted.
- R3: A pin change that settles before clock edge k appears on the filtered level right after edge k+1+`FILT_CYCLES`, and not before.
- R4: `bclk_rise` and `bclk_fall` are one-cycle active-high strobes, raised in the first cycle after the filtered clock level has gone high or low.
- R5: `start_evt` is a one-cycle active-high strobe, raised when the filtered data level falls while the filtered clock level is high.
- R6: `stop_evt` is a one-cycle active-high strobe, raised when the filtered data level rises while the filtered clock level is high.
- R7: A start or stop takes priority over a clock-rise strobe in the same cycle, so at most one of the four strobes is high in any cycle. A data change while the filtered clock is low raises no event.
- R8: `bus_busy` becomes 1 in the cycle after a start and 0 in the cycle after a stop.
- R9: `dat_oe` (1 = pull the data line low) copies `dat_drive_req` only while the filtered clock is low. The first update comes at the earliest `HOLD_CYCLES`+1 edges after the cycle that carries `bclk_fall`. Once that hold has run out, a new request is taken at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_in | input | 1 | Raw bus clock pin |
| bus_dat_in | input | 1 | Raw bus data pin |
| dat_drive_req | input | 1 | Engine request to pull the data line low |
| bclk_level | output | 1 | Filtered clock level |
| bdat_level | output | 1 | Filtered data level |
| start_evt | output | 1 | One-cycle start strobe |
| stop_evt | output | 1 | One-cycle stop strobe |
| bclk_rise | output | 1 | One-cycle clock rising strobe |
| bclk_fall | output | 1 | One-cycle clock falling strobe |
| bus_busy | output | 1 | Set between a start and a stop |
| dat_oe | output | 1 | Delayed data drive enable (1 = drive low) |

## Verification
The assertions check these on every cycle:
- at most one strobe is high;
- a start or a stop matches the filtered levels around it;
- the busy flag follows starts and stops;
- the drive enable never changes while the clock is high, or before the hold window after a clock fall has elapsed.

Only the bench scenarios can show the rest:
- that spikes one cycle short of the filter length vanish while spikes of exactly that length pass;
- the exact filter latency;
- the exact edge on which the drive enable first updates;
- the order of the events on real pin sequences, including a clock rise that coincides with a data change.

// File: rtl/twowire_line_frontend.sv
`timescale 1ns/1ps
module twowire_line_frontend #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 10,
  parameter int HOLD_CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk_in,
  input  logic bus_dat_in,
  input  logic dat_drive_req,
  output logic bclk_level,
  output logic bdat_level,
  output logic start_evt,
  output logic stop_evt,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic bus_busy,
  output logic dat_oe
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [1:0] raw, lvl, lvl_d;
  logic [HW-1:0] hold_cnt;

  assign raw = {bus_dat_in, bus_clk_in};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [SYNC_STAGES-1:0] sync;
    logic [FW-1:0] cnt;
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync <= '1;
        cnt  <= '0;
        q    <= 1'b1;
      end else begin
        sync <= {sync[SYNC_STAGES-2:0], raw[i]};
        if (sync[SYNC_STAGES-1] == q) begin
          cnt <= '0;
        end else if (cnt == FW'(FILT_CYCLES - 1)) begin
          q   <= sync[SYNC_STAGES-1];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign lvl[i] = q;
  end

  assign bclk_level = lvl[0];
  assign bdat_level = lvl[1];

  assign start_evt = bclk_level &  lvl_d[1] & ~bdat_level;
  assign stop_evt  = bclk_level & ~lvl_d[1] &  bdat_level;
  assign bclk_rise = bclk_level & ~lvl_d[0] & ~(start_evt | stop_evt);
  assign bclk_fall = ~bclk_level & lvl_d[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d    <= 2'b11;
      bus_busy <= 1'b0;
      hold_cnt <= '0;
      dat_oe   <= 1'b0;
    end else begin
      lvl_d <= lvl;
      if (start_evt)     bus_busy <= 1'b1;
      else if (stop_evt) bus_busy <= 1'b0;
      if (bclk_fall)            hold_cnt <= HW'(HOLD_CYCLES);
      else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
      if (!bclk_level && !bclk_fall && hold_cnt == '0)
        dat_oe <= dat_drive_req;
    end
  end
endmodule

// File: rtl/twowire_line_frontend_chk.sv
`timescale 1ns/1ps
module twowire_line_frontend_chk #(
  parameter int HOLD_CYCLES = 60
) (
  input logic clk,
  input logic rst_n,
  input logic bclk_level,
  input logic bdat_level,
  input logic start_evt,
  input logic stop_evt,
  input logic bclk_rise,
  input logic bclk_fall,
  input logic bus_busy,
  input logic dat_oe
);
  localparam int GW = $clog2(HOLD_CYCLES + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap <= GW'(HOLD_CYCLES);
    else if (bclk_fall)              gap <= '0;
    else if (gap < GW'(HOLD_CYCLES)) gap <= gap + 1'b1;
  end

  assert_events_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, bclk_rise, bclk_fall}));

  assert_start_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> bclk_level && !bdat_level && $past(bdat_level));

  assert_stop_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> bclk_level && bdat_level && !$past(bdat_level));

  assert_rise_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |-> bclk_level && !$past(bclk_level));

  assert_fall_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |-> !bclk_level && $past(bclk_level));

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> bus_busy);

  assert_busy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !bus_busy);

  assert_oe_clock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe != $past(dat_oe)) |-> !$past(bclk_level));

  assert_oe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe != $past(dat_oe)) |-> (gap >= GW'(HOLD_CYCLES)));
endmodule

bind twowire_line_frontend twowire_line_frontend_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_level(bclk_level), .bdat_level(bdat_level),
  .start_evt(start_evt), .stop_evt(stop_evt), .bclk_rise(bclk_rise),
  .bclk_fall(bclk_fall), .bus_busy(bus_busy), .dat_oe(dat_oe)
);

// File: tb/twowire_line_frontend_bench.sv
`timescale 1ns/1ps
module twowire_line_frontend_bench;
  localparam int FILT = 10;
  localparam int HOLD = 60;
  localparam byte EV_S = "S", EV_P = "P", EV_R = "R", EV_F = "F";

  logic clk = 1'b0, rst_n = 1'b0, clk_pin = 1'b1, dat_pin = 1'b1, drv_req = 1'b0;
  logic bclk_level, bdat_level, start_evt, stop_evt, bclk_rise, bclk_fall, bus_busy, dat_oe;
  int checks = 0, errors = 0;
  byte exp_q[$];
  byte got_ev, exp_ev;

  always #2.5 clk = ~clk;

  twowire_line_frontend #(.SYNC_STAGES(2), .FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD)) u_twowire_line_frontend (
    .clk(clk), .rst_n(rst_n), .bus_clk_in(clk_pin), .bus_dat_in(dat_pin),
    .dat_drive_req(drv_req), .bclk_level(bclk_level), .bdat_level(bdat_level),
    .start_evt(start_evt), .stop_evt(stop_evt), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .bus_busy(bus_busy), .dat_oe(dat_oe)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_clk(bit v);
    clk_pin = v;
    exp_q.push_back(v ? EV_R : EV_F);
    tick(FILT + 4);
    chk("R4 clock level", bclk_level, v);
  endtask

  task automatic drive_dat(bit v);
    dat_pin = v;
    if (clk_pin) exp_q.push_back(v ? EV_P : EV_S);
    tick(FILT + 4);
    chk("R2 data level", bdat_level, v);
  endtask

  // monitor: pops one expected event per observed strobe (R4/R5/R6/R7)
  always @(negedge clk) begin
    if (rst_n && (start_evt || stop_evt || bclk_rise || bclk_fall)) begin
      got_ev = start_evt ? EV_S : stop_evt ? EV_P : bclk_rise ? EV_R : EV_F;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected event: actual %c expected none", got_ev);
      end else begin
        exp_ev = exp_q.pop_front();
        chk("R4/R5/R6 event order", int'(got_ev), int'(exp_ev));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 clock level", bclk_level, 1);
    chk("R1 data level", bdat_level, 1);
    chk("R1 busy", bus_busy, 0);
    chk("R1 drive enable", dat_oe, 0);
    chk("R1 no strobes", int'({start_evt, stop_evt, bclk_rise, bclk_fall}), 0);

    // R5 / R8 start from idle
    drive_dat(0);
    chk("R8 busy after start", bus_busy, 1);
    drive_clk(0);
    // R3 latency, data change while clock low (R7: no event)
    dat_pin = 1'b1;
    tick(FILT + 1);
    chk("R3 level before latency", bdat_level, 0);
    tick(1);
    chk("R3 level after latency", bdat_level, 1);
    tick(4);
    drive_clk(1);
    drive_clk(0);
    drive_dat(0);
    drive_clk(1);
    // R6 / R8 stop
    drive_dat(1);
    chk("R8 busy after stop", bus_busy, 0);

    // R2 short spikes rejected
    dat_pin = 1'b0; tick(FILT - 1); dat_pin = 1'b1; tick(FILT + 4);
    chk("R2 data spike rejected", bdat_level, 1);
    chk("R2 no busy from spike", bus_busy, 0);
    clk_pin = 1'b0; tick(FILT - 1); clk_pin = 1'b1; tick(FILT + 4);
    chk("R2 clock spike rejected", bclk_level, 1);
    // R2 pulse of exactly FILT edges accepted: start then stop
    exp_q.push_back(EV_S); exp_q.push_back(EV_P);
    dat_pin = 1'b0; tick(FILT); dat_pin = 1'b1; tick(FILT + 4);
    chk("R2 full pulse queue drained", exp_q.size(), 0);
    chk("R2 busy cleared after pulse", bus_busy, 0);

    // R7 priority: clock rises with data falling in the same cycle
    drive_clk(0);
    clk_pin = 1'b1; dat_pin = 1'b0; exp_q.push_back(EV_S);
    tick(FILT + 4);
    chk("R7 busy after merged start", bus_busy, 1);
    drive_clk(0);
    drive_dat(0);
    clk_pin = 1'b1; dat_pin = 1'b1; exp_q.push_back(EV_P);
    tick(FILT + 4);
    chk("R7 busy after merged stop", bus_busy, 0);

    // R9 drive enable held while clock high
    drv_req = 1'b1;
    tick(HOLD + 20);
    chk("R9 no update while clock high", dat_oe, 0);
    // R9 first update after hold window
    clk_pin = 1'b0; exp_q.push_back(EV_F);
    tick(FILT + HOLD + 3);
    chk("R9 enable before hold expiry", dat_oe, 0);
    tick(1);
    chk("R9 enable at hold expiry", dat_oe, 1);
    drv_req = 1'b0;
    tick(1);
    chk("R9 prompt update after hold", dat_oe, 0);
    drive_clk(1);

    tick(10);
    chk("R7 scoreboard empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule